// File: doc/BRIEF.md
# Masked Interrupt Cause Logic

This block gathers every interrupt event of a processor core into one 32-bit cause vector and filters it through a status mask. Some events come from outside the core: a reset request and a set of device request lines. Others come from inside it: illegal instruction, misalignment, page faults on fetch and on load/store, trap, and the fixed- and floating-point arithmetic exceptions. The block detects two of the internal causes itself. It finds misaligned addresses from the delayed PC and from the load/store effective address and access size. It also catches illegal special-register moves made in user mode.

Some cause positions can be masked and the rest always count. When at least one surviving cause bit is set, the block raises the jump-to-service-routine request `jisr` in the same cycle. At the next clock edge it stores the masked vector in a cause register, and stores the delayed PC and the effective address in two exception address registers. The core reads these registers when the service routine starts. When the core emulates a virtual machine, the page-fault positions are forced to zero, so translation faults cannot reach the handler.

Top module: `irq_cause_unit`

## Requirements
- R1: Cause index 0 follows `ext_reset_line`, cannot be masked, and raises `jisr` whenever it is high.
- R2: Indices 1 to 5 cannot be masked. They are, in order, illegal instruction, misalignment, fetch page fault, load/store page fault and trap.
- R3: Index 12 is the unimplemented floating-point operation cause and cannot be masked.
- R4: Index 6 is fixed-point overflow. Indices 7 to 11 take `fp_flags[0]` to `fp_flags[4]`, which are overflow, underflow, inexact, divide-by-zero and invalid. These six bits reach the masked vector only when the matching `status_mask` bit is 1. `jisr` is the OR of all 32 masked bits.
- R5: An index j from 13 to 31 takes `dev_irq[j-13]` and can be masked by `status_mask[j]`.
- R6: The misalignment cause is set when `dpc[1:0]` is not zero.
- R7: The misalignment cause is also set when `ls_valid` is 1 and the effective address is not a multiple of the access size. `acc_size` selects the size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. When `ls_valid` is 0, `ea` has no effect on misalignment.
- R8: The illegal-instruction cause is set in two cases. The first is `ill_opcode`. The second is `spr_move` with `user_mode` at 1 and `spr_addr` outside the set 6, 7, 8. In system mode, any `spr_addr` is legal.
- R9: When `vm_mode` is 1, `pf_fetch` and `pf_ldst` do not set causes 3 and 4.
- R10: While `rst` is high, `jisr` is 0. A clock edge with `rst` high clears `cause_q`, `epc_q` and `edata_q`.
- R11: On a clock edge with `jisr` high, `cause_q` takes the masked vector, `epc_q` takes `dpc` and `edata_q` takes `ea`. Without `jisr`, all three registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_reset_line | input | 1 | External reset request (cause 0) |
| dev_irq | input | 19 | Device request lines (causes 13 to 31) |
| ill_opcode | input | 1 | Decoder found an illegal opcode |
| spr_move | input | 1 | Current instruction moves to or from a special register |
| spr_addr | input | 5 | Special register address of that move |
| user_mode | input | 1 | 1 = user mode, 0 = system mode |
| vm_mode | input | 1 | Virtual-machine view: page-fault causes suppressed |
| pf_fetch | input | 1 | Page fault on instruction fetch |
| pf_ldst | input | 1 | Page fault on load/store |
| trap | input | 1 | Trap instruction |
| fxp_ovf | input | 1 | Fixed-point overflow |
| fp_flags | input | 5 | FP overflow, underflow, inexact, divide-by-zero, invalid (bit 0 to 4) |
| fp_unimpl | input | 1 | Unimplemented FP operation |
| status_mask | input | 32 | Mask bit per cause index |
| dpc | input | ADDR_W (32) | Delayed program counter |
| ea | input | ADDR_W (32) | Load/store effective address |
| ls_valid | input | 1 | A load/store is present |
| acc_size | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| jisr | output | 1 | Jump to service routine |
| cause_q | output | 32 | Registered masked cause vector |
| epc_q | output | ADDR_W (32) | Registered delayed PC at the interrupt |
| edata_q | output | ADDR_W (32) | Registered effective address at the interrupt |

## Verification
The block holds little state, so any error shows at the ports within one cycle. A wrong mask or cause mapping changes `jisr` in the same cycle. A wrong capture condition shows on the next edge as `cause_q`, `epc_q` or `edata_q` changing when they should hold, or holding a stale value. The bench drives both masked and unmasked patterns for every cause group, every access size, both modes and both views. A behavioural model predicts all four outputs, and the bench compares them against it every cycle.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

   localparam int CAUSE_W   = 32;
   localparam int DEV_BASE  = 13;
   localparam int DEV_LINES = CAUSE_W - DEV_BASE;
   localparam int FP_FLAGS  = 5;

   localparam int IX_RESET  = 0;
   localparam int IX_ILL    = 1;
   localparam int IX_MAL    = 2;
   localparam int IX_PFF    = 3;
   localparam int IX_PFLS   = 4;
   localparam int IX_TRAP   = 5;
   localparam int IX_FXOVF  = 6;
   localparam int IX_FPLO   = 7;
   localparam int IX_FPUNIM = 12;

   typedef enum logic [1:0] {
      ACC_BYTE  = 2'd0,
      ACC_HALF  = 2'd1,
      ACC_WORD  = 2'd2,
      ACC_DWORD = 2'd3
   } acc_size_e;

   function automatic bit cause_is_maskable(int j);
      return ((j >= IX_FXOVF) && (j < IX_FPUNIM)) || (j >= DEV_BASE);
   endfunction

   function automatic logic [CAUSE_W-1:0] maskable_vec();
      logic [CAUSE_W-1:0] v;
      for (int j = 0; j < CAUSE_W; j++) v[j] = cause_is_maskable(j);
      return v;
   endfunction

   function automatic logic [2:0] size_low_mask(acc_size_e s);
      case (s)
         ACC_BYTE:  return 3'b000;
         ACC_HALF:  return 3'b001;
         ACC_WORD:  return 3'b011;
         default:   return 3'b111;
      endcase
   endfunction

endpackage

// File: rtl/irq_misalign_det.sv
module irq_misalign_det
   import irq_cause_pkg::*;
(
   input  logic [1:0] dpc_lo,
   input  logic [2:0] ea_lo,
   input  logic       ls_valid,
   input  acc_size_e  acc_size,
   output logic       misalign
);

   logic fetch_bad;
   logic data_bad;

   always_comb begin
      fetch_bad = |dpc_lo;
      data_bad  = ls_valid && ((ea_lo & size_low_mask(acc_size)) != 3'b000);
      misalign  = fetch_bad || data_bad;
   end

endmodule

// File: rtl/irq_spr_guard.sv
module irq_spr_guard #(
   parameter int SPR_AW = 5
) (
   input  logic              user_mode,
   input  logic              spr_move,
   input  logic [SPR_AW-1:0] spr_addr,
   output logic              spr_illegal
);

   localparam logic [SPR_AW-1:0] USER_SPR_LO = SPR_AW'(6);
   localparam logic [SPR_AW-1:0] USER_SPR_HI = SPR_AW'(8);

   logic user_visible;

   always_comb begin
      user_visible = (spr_addr >= USER_SPR_LO) && (spr_addr <= USER_SPR_HI);
      spr_illegal  = user_mode && spr_move && !user_visible;
   end

endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
   import irq_cause_pkg::*;
#(
   parameter int WIDTH = CAUSE_W
) (
   input  logic [WIDTH-1:0] raw,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] masked,
   output logic             any
);

   genvar j;
   generate
      for (j = 0; j < WIDTH; j++) begin : g_bit
         if (cause_is_maskable(j)) begin : g_maskable
            assign masked[j] = raw[j] & mask[j];
         end else begin : g_fixed
            assign masked[j] = raw[j];
            logic unused_mask;
            assign unused_mask = mask[j];
         end
      end
   endgenerate

   assign any = |masked;

endmodule

// File: rtl/irq_capture_regs.sv
module irq_capture_regs #(
   parameter int CW     = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [CW-1:0]     cause_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [CW-1:0]     cause_q,
   output logic [ADDR_W-1:0] epc_q,
   output logic [ADDR_W-1:0] edata_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cause_q <= '0;
         epc_q   <= '0;
         edata_q <= '0;
      end else if (take) begin
         cause_q <= cause_in;
         epc_q   <= pc_in;
         edata_q <= addr_in;
      end
   end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
   import irq_cause_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ext_reset_line,
   input  logic [DEV_LINES-1:0] dev_irq,
   input  logic                 ill_opcode,
   input  logic                 spr_move,
   input  logic [4:0]           spr_addr,
   input  logic                 user_mode,
   input  logic                 vm_mode,
   input  logic                 pf_fetch,
   input  logic                 pf_ldst,
   input  logic                 trap,
   input  logic                 fxp_ovf,
   input  logic [FP_FLAGS-1:0]  fp_flags,
   input  logic                 fp_unimpl,
   input  logic [CAUSE_W-1:0]   status_mask,
   input  logic [ADDR_W-1:0]    dpc,
   input  logic [ADDR_W-1:0]    ea,
   input  logic                 ls_valid,
   input  logic [1:0]           acc_size,
   output logic                 jisr,
   output logic [CAUSE_W-1:0]   cause_q,
   output logic [ADDR_W-1:0]    epc_q,
   output logic [ADDR_W-1:0]    edata_q
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("irq_cause_unit: ADDR_W must be at least 3");
      end
      if (IX_FPLO + FP_FLAGS != IX_FPUNIM) begin : g_bad_fp_span
         $error("irq_cause_unit: FP flag span does not meet index 12");
      end
      if (DEV_LINES < 1) begin : g_bad_dev
         $error("irq_cause_unit: no device lines left");
      end
   endgenerate

   logic                 misalign;
   logic                 spr_illegal;
   logic [CAUSE_W-1:0]   raw_cause;
   logic [CAUSE_W-1:0]   masked_cause;
   logic                 any_cause;

   irq_misalign_det i_misalign (
      .dpc_lo   (dpc[1:0]),
      .ea_lo    (ea[2:0]),
      .ls_valid (ls_valid),
      .acc_size (acc_size_e'(acc_size)),
      .misalign (misalign)
   );

   irq_spr_guard #(.SPR_AW(5)) i_spr_guard (
      .user_mode   (user_mode),
      .spr_move    (spr_move),
      .spr_addr    (spr_addr),
      .spr_illegal (spr_illegal)
   );

   always_comb begin
      raw_cause            = '0;
      raw_cause[IX_RESET]  = ext_reset_line;
      raw_cause[IX_ILL]    = ill_opcode || spr_illegal;
      raw_cause[IX_MAL]    = misalign;
      raw_cause[IX_PFF]    = pf_fetch && !vm_mode;
      raw_cause[IX_PFLS]   = pf_ldst && !vm_mode;
      raw_cause[IX_TRAP]   = trap;
      raw_cause[IX_FXOVF]  = fxp_ovf;
      raw_cause[IX_FPLO +: FP_FLAGS] = fp_flags;
      raw_cause[IX_FPUNIM] = fp_unimpl;
      raw_cause[DEV_BASE +: DEV_LINES] = dev_irq;
   end

   irq_cause_mask #(.WIDTH(CAUSE_W)) i_mask (
      .raw    (raw_cause),
      .mask   (status_mask),
      .masked (masked_cause),
      .any    (any_cause)
   );

   assign jisr = any_cause && !rst;

   irq_capture_regs #(.CW(CAUSE_W), .ADDR_W(ADDR_W)) i_capture (
      .clk      (clk),
      .rst      (rst),
      .take     (jisr),
      .cause_in (masked_cause),
      .pc_in    (dpc),
      .addr_in  (ea),
      .cause_q  (cause_q),
      .epc_q    (epc_q),
      .edata_q  (edata_q)
   );

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
   import irq_cause_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic               clk,
   input logic               rst,
   input logic               ext_reset_line,
   input logic               ill_opcode,
   input logic               trap,
   input logic [CAUSE_W-1:0] status_mask,
   input logic [ADDR_W-1:0]  dpc,
   input logic [ADDR_W-1:0]  ea,
   input logic               jisr,
   input logic [CAUSE_W-1:0] cause_q,
   input logic [ADDR_W-1:0]  epc_q,
   input logic [ADDR_W-1:0]  edata_q
);

   localparam logic [CAUSE_W-1:0] MASKABLE = maskable_vec();

   always @(posedge clk) begin
      if (rst) begin
         a_r10_quiet_in_reset: assert (!jisr);
      end
   end

   a_r10_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cause_q == '0 && epc_q == '0 && edata_q == '0));

   a_r1_reset_line_unmasked: assert property (@(posedge clk) disable iff (rst)
      ext_reset_line |-> jisr);

   a_r2_internal_unmasked: assert property (@(posedge clk) disable iff (rst)
      (ill_opcode || trap) |-> jisr);

   a_r4_mask_respected: assert property (@(posedge clk) disable iff (rst)
      jisr |=> ((cause_q & MASKABLE & ~$past(status_mask)) == '0));

   a_r11_capture: assert property (@(posedge clk) disable iff (rst)
      jisr |=> (epc_q == $past(dpc) && edata_q == $past(ea) && cause_q != '0));

   a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !jisr |=> ($stable(cause_q) && $stable(epc_q) && $stable(edata_q)));

endmodule

bind irq_cause_unit irq_cause_chk #(.ADDR_W(ADDR_W)) i_cause_chk (
   .clk            (clk),
   .rst            (rst),
   .ext_reset_line (ext_reset_line),
   .ill_opcode     (ill_opcode),
   .trap           (trap),
   .status_mask    (status_mask),
   .dpc            (dpc),
   .ea             (ea),
   .jisr           (jisr),
   .cause_q        (cause_q),
   .epc_q          (epc_q),
   .edata_q        (edata_q)
);

// File: tb/test_irq_cause_unit.sv
`timescale 1ns/1ps
module test_irq_cause_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ext_reset_line = 1'b0;
   logic [18:0] dev_irq = '0;
   logic        ill_opcode = 1'b0;
   logic        spr_move = 1'b0;
   logic [4:0]  spr_addr = '0;
   logic        user_mode = 1'b0;
   logic        vm_mode = 1'b0;
   logic        pf_fetch = 1'b0;
   logic        pf_ldst = 1'b0;
   logic        trap = 1'b0;
   logic        fxp_ovf = 1'b0;
   logic [4:0]  fp_flags = '0;
   logic        fp_unimpl = 1'b0;
   logic [31:0] status_mask = '0;
   logic [31:0] dpc = '0;
   logic [31:0] ea = '0;
   logic        ls_valid = 1'b0;
   logic [1:0]  acc_size = '0;
   logic        jisr;
   logic [31:0] cause_q;
   logic [31:0] epc_q;
   logic [31:0] edata_q;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [31:0] m_cause = '0;
   logic [31:0] m_epc = '0;
   logic [31:0] m_edata = '0;

   always #2.5 clk = ~clk;

   irq_cause_unit i_irq_cause_unit (
      .clk(clk), .rst(rst), .ext_reset_line(ext_reset_line), .dev_irq(dev_irq),
      .ill_opcode(ill_opcode), .spr_move(spr_move), .spr_addr(spr_addr),
      .user_mode(user_mode), .vm_mode(vm_mode), .pf_fetch(pf_fetch),
      .pf_ldst(pf_ldst), .trap(trap), .fxp_ovf(fxp_ovf), .fp_flags(fp_flags),
      .fp_unimpl(fp_unimpl), .status_mask(status_mask), .dpc(dpc), .ea(ea),
      .ls_valid(ls_valid), .acc_size(acc_size), .jisr(jisr), .cause_q(cause_q),
      .epc_q(epc_q), .edata_q(edata_q)
   );

   function automatic bit can_mask(int j);
      return (j >= 6 && j <= 11) || j >= 13;
   endfunction

   function automatic logic [31:0] model_masked();
      logic [31:0] c = '0;
      int nbytes = 1 << acc_size;
      bit bad_spr = !(spr_addr == 5'd6 || spr_addr == 5'd7 || spr_addr == 5'd8);
      c[0] = ext_reset_line;
      c[1] = ill_opcode || (spr_move && user_mode && bad_spr);
      c[2] = (dpc % 4 != 0) || (ls_valid && (ea % nbytes != 0));
      c[3] = pf_fetch && !vm_mode;
      c[4] = pf_ldst && !vm_mode;
      c[5] = trap;
      c[6] = fxp_ovf;
      for (int k = 0; k < 5; k++) c[7 + k] = fp_flags[k];
      c[12] = fp_unimpl;
      for (int k = 0; k < 19; k++) c[13 + k] = dev_irq[k];
      for (int j = 0; j < 32; j++) if (can_mask(j) && !status_mask[j]) c[j] = 1'b0;
      return c;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_srcs();
      ext_reset_line = 0; dev_irq = '0; ill_opcode = 0; spr_move = 0; spr_addr = '0;
      user_mode = 0; vm_mode = 0; pf_fetch = 0; pf_ldst = 0; trap = 0; fxp_ovf = 0;
      fp_flags = '0; fp_unimpl = 0; status_mask = '0; ls_valid = 0; acc_size = '0;
      dpc = 32'h0000_1000; ea = 32'h0000_2000;
   endtask

   // inputs are set by the caller after a negedge; this samples and advances
   task automatic step(string tag);
      logic [31:0] mc;
      logic exp_j;
      #1;
      mc = model_masked();
      exp_j = !rst && (mc != 0);
      check(tag, "jisr", {31'b0, jisr}, {31'b0, exp_j});
      if (rst) begin
         m_cause = '0; m_epc = '0; m_edata = '0;
      end else if (exp_j) begin
         m_cause = mc; m_epc = dpc; m_edata = ea;
      end
      @(posedge clk); #1;
      check(tag, "cause_q", cause_q, m_cause);
      check(tag, "epc_q", epc_q, m_epc);
      check(tag, "edata_q", edata_q, m_edata);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R10: reset with live sources
      clear_srcs(); ext_reset_line = 1; trap = 1; dpc = 32'h55;
      step("R10");
      step("R10");
      rst = 0;
      clear_srcs();
      step("R10");
      // R1
      ext_reset_line = 1; dpc = 32'h0000_0100; ea = 32'h0000_0ABC;
      step("R1");
      clear_srcs(); step("R11");
      // R2
      ill_opcode = 1; dpc = 32'h0000_0204; step("R2");
      clear_srcs(); trap = 1; ea = 32'h0000_0330; step("R2");
      clear_srcs(); dpc = 32'h0000_0402; step("R2");
      // R3
      clear_srcs(); fp_unimpl = 1; step("R3");
      // R4: each maskable arithmetic cause, masked then enabled
      for (int k = 0; k < 6; k++) begin
         clear_srcs();
         if (k == 0) fxp_ovf = 1; else fp_flags[k-1] = 1;
         status_mask = ~(32'h1 << (6 + k));
         step("R4");
         status_mask = 32'h1 << (6 + k); dpc = 32'h0000_5000 + k * 4;
         step("R4");
      end
      clear_srcs(); fxp_ovf = 1; fp_flags = 5'h1F; status_mask = 32'h0000_0A80;
      step("R4");
      // R5
      for (int k = 0; k < 19; k += 3) begin
         clear_srcs(); dev_irq[k] = 1; status_mask = 32'hFFFF_FFFF ^ (32'h1 << (13 + k));
         step("R5");
         status_mask = 32'h1 << (13 + k); ea = 32'h0000_7000 + k;
         step("R5");
      end
      // R6
      for (int k = 1; k < 4; k++) begin
         clear_srcs(); dpc = 32'h0000_0800 + k; step("R6");
      end
      // R7
      for (int s = 0; s < 4; s++) begin
         for (int off = 0; off < 8; off++) begin
            clear_srcs(); ls_valid = 1; acc_size = 2'(s); ea = 32'h0000_9000 + off;
            step("R7");
         end
      end
      clear_srcs(); ls_valid = 0; acc_size = 2'd3; ea = 32'h0000_9003; step("R7");
      // R8
      for (int a = 0; a < 32; a++) begin
         clear_srcs(); spr_move = 1; spr_addr = 5'(a); user_mode = 1; step("R8");
      end
      clear_srcs(); spr_move = 1; spr_addr = 5'd20; user_mode = 0; step("R8");
      clear_srcs(); spr_move = 0; spr_addr = 5'd20; user_mode = 1; step("R8");
      // R9
      clear_srcs(); pf_fetch = 1; step("R9");
      clear_srcs(); pf_ldst = 1; step("R9");
      clear_srcs(); pf_fetch = 1; pf_ldst = 1; vm_mode = 1; dpc = 32'h0000_AAA0; step("R9");
      // R11: hold without request
      clear_srcs(); dpc = 32'h1234_5678 & 32'hFFFF_FFFC; ea = 32'h0BAD_F00D; step("R11");
      // mixed patterns
      begin
         logic [31:0] s = 32'h1ACE_B00C;
         for (int n = 0; n < 200; n++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            clear_srcs();
            status_mask = s; dev_irq = 19'(s >> 7);
            ill_opcode = (s[3:0] == 0); trap = (s[7:4] == 0);
            fxp_ovf = s[8]; fp_flags = s[13:9]; fp_unimpl = (s[17:14] == 0);
            pf_fetch = s[18]; pf_ldst = s[19]; vm_mode = s[20]; user_mode = s[21];
            spr_move = s[22]; spr_addr = s[27:23]; ls_valid = s[28]; acc_size = s[30:29];
            dpc = {s[15:0], s[31:16]} & ~32'h3; if (s[31] && s[2]) dpc[0] = 1;
            ea = s ^ 32'h5A5A_5A5A;
            ext_reset_line = (s[11:4] == 8'h5A);
            step("R4");
         end
      end
      // R10 again mid-run
      clear_srcs(); trap = 1; rst = 1; step("R10");
      rst = 0; clear_srcs(); step("R10");
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule